// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block is a timer that raises periodic events. A power-of-two prescaler divides the bus clock. Each prescaled tick decrements a 16-bit down-counter. When the counter is at zero and a tick arrives, the counter either reloads from a programmable modulus (periodic mode) or wraps to all ones (free-running mode). In both modes a sticky event flag is set, and if interrupts are enabled the interrupt request goes high.

Software reaches the timer through a simple synchronous register port with three registers:

- **Control/status** at address 0. Bit 0 is run enable, bit 1 is periodic-reload mode, bit 2 is the event flag, bit 3 is interrupt enable, bit 4 is immediate-load mode, and bits 11:8 hold the prescale code.
- **Modulus** at address 1.
- **Live counter** at address 2, read-only.

Address 3 reads as zero. Writes are taken on the rising clock edge when `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `pit_timer`

## Requirements
- R1: With prescale code C (0 to 15) and modulus M, the first event flag appears exactly (M+1)·2^C clock edges after the edge that enables the timer.
- R2: In periodic mode (control bit 1 = 1), the counter holds M on the edge where the flag sets. It counts down again from there, giving a period of (M+1)·2^C edges.
- R3: In free-running mode (control bit 1 = 0), the counter goes from zero to 16'hFFFF on the terminal tick and then keeps decrementing.
- R4: The flag (control bit 2) sets on the terminal tick. Writing a 1 to bit 2 clears it. Writing a 0 to bit 2 leaves it unchanged.
- R5: If a flag-clear write lands on the same edge as a terminal tick, the flag reads 1 afterwards.
- R6: `irq` is high exactly when both the interrupt-enable bit (control bit 3) and the flag are set.
- R7: While run enable is 0, the counter does not change, except through an immediate load, and no new flag is raised.
- R8: The prescale code, reload mode and immediate-load mode fields take a written value only if the timer was disabled before that write. Writes to these fields while the timer runs are dropped.
- R9: With immediate-load mode set (control bit 4 = 1), a modulus write puts the written value into the counter on the same edge. With it clear, the counter keeps counting and the new modulus is used only at the next reload.
- R10: After reset, control reads 0, the modulus and the counter read 16'hFFFF, and `irq` is 0. The counter value can be read at address 2 at any time.
- R11: The write that sets run enable while the timer is stopped loads the counter from the modulus and restarts the prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 modulus, 2 counter |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag-clear write landing on the very edge of a terminal tick. The stimulus gets there by starting the timer with no prescaling and a small modulus, then counting whole edges from the enabling write so that the clearing write meets the fourth edge. Exact period checks across several prescale codes depend on the prescaler restart. Because of that restart, each measured interval begins at a known phase.

// File: rtl/pit_pkg.sv
package pit_pkg;
    // register selects on the bus port
    localparam int SEL_CTRL = 0;
    localparam int SEL_MOD  = 1;
    localparam int SEL_CNT  = 2;

    // control/status field positions
    localparam int BIT_EN   = 0;
    localparam int BIT_RLD  = 1;
    localparam int BIT_FLAG = 2;
    localparam int BIT_IE   = 3;
    localparam int BIT_OW   = 4;
    localparam int PRE_LSB  = 8;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0] div_d, div_q;
    logic [PRE_W-1:0] limit;

    // terminal value of the divider: 2^code - 1
    assign limit = PRE_W'((64'd1 << code) - 64'd1);
    assign tick  = run && !restart && (div_q == limit);

    always_comb begin
        div_d = div_q;
        if (restart) begin
            div_d = '0;
        end else if (run) begin
            div_d = tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pit_downcounter.sv
module pit_downcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] count,
    output logic             tc
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tc    = tick && (cnt_q == '0);
    assign count = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tc) begin
            cnt_d = reload_mode ? modulus : '1;
        end else if (tick) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic              rld;
        logic              ie;
        logic              ow;
        logic              flag;
        logic [CODE_W-1:0] pre;
        logic [CNT_W-1:0]  modv;
    } state_t;

    state_t           r_d, r_q;
    logic             ctrl_wr, mod_wr, start, load;
    logic [CNT_W-1:0] load_val, cnt;
    logic             tick, tc;
    logic             unused_wbits;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(SEL_CTRL));
    assign mod_wr   = bus_wr && (bus_addr == ADDR_W'(SEL_MOD));
    assign start    = ctrl_wr && bus_wdata[BIT_EN] && !r_q.en;
    assign load     = start || (mod_wr && r_q.ow);
    assign load_val = start ? r_q.modv : bus_wdata;
    assign irq      = r_q.ie && r_q.flag;
    assign unused_wbits = ^bus_wdata;

    pit_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.en),
        .restart (start),
        .code    (r_q.pre),
        .tick    (tick)
    );

    pit_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load        (load),
        .load_val    (load_val),
        .reload_mode (r_q.rld),
        .modulus     (r_q.modv),
        .count       (cnt),
        .tc          (tc)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.en = bus_wdata[BIT_EN];
            r_d.ie = bus_wdata[BIT_IE];
            if (!r_q.en) begin
                r_d.rld = bus_wdata[BIT_RLD];
                r_d.ow  = bus_wdata[BIT_OW];
                r_d.pre = bus_wdata[PRE_LSB +: CODE_W];
            end
        end
        if (mod_wr) begin
            r_d.modv = bus_wdata;
        end
        if (tc) begin
            r_d.flag = 1'b1;
        end else if (ctrl_wr && bus_wdata[BIT_FLAG]) begin
            r_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.modv <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(SEL_CTRL)) begin
            bus_rdata[BIT_EN]   = r_q.en;
            bus_rdata[BIT_RLD]  = r_q.rld;
            bus_rdata[BIT_FLAG] = r_q.flag;
            bus_rdata[BIT_IE]   = r_q.ie;
            bus_rdata[BIT_OW]   = r_q.ow;
            bus_rdata[PRE_LSB +: CODE_W] = r_q.pre;
        end else if (bus_addr == ADDR_W'(SEL_MOD)) begin
            bus_rdata = r_q.modv;
        end else if (bus_addr == ADDR_W'(SEL_CNT)) begin
            bus_rdata = cnt;
        end
    end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              rld,
    input logic              ie,
    input logic              flag,
    input logic [CODE_W-1:0] pre,
    input logic [CNT_W-1:0]  modv,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick,
    input logic              tc,
    input logic              load,
    input logic              irq
);
    // R4
    flag_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> flag);

    // R2
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && rld && !load) |=> (cnt == $past(modv)));

    // R3
    wrap_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !rld && !load) |=> (cnt == '1));

    // R7
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt));

    // R7
    no_tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);

    // R8
    pre_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(pre));

    // R6
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie && flag));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (r_q.en),
    .rld   (r_q.rld),
    .ie    (r_q.ie),
    .flag  (r_q.flag),
    .pre   (r_q.pre),
    .modv  (r_q.modv),
    .cnt   (cnt),
    .tick  (tick),
    .tc    (tc),
    .load  (load),
    .irq   (irq)
);

// File: tb/pit_timer_test.sv
module pit_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv, rv2;

    always #2.5 clk = ~clk;

    pit_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {prescale code, modulus, edges from enable to first flag}
    localparam int VEC [6][3] = '{
        '{0, 3, 4}, '{1, 3, 8}, '{2, 5, 24},
        '{0, 0, 1}, '{3, 2, 24}, '{4, 1, 32}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        rd(2'd0, rv); check("R10 ctrl reset", rv, 16'h0000);
        rd(2'd1, rv); check("R10 modulus reset", rv, 16'hFFFF);
        rd(2'd2, rv); check("R10 count reset", rv, 16'hFFFF);
        check("R10 irq reset", irq, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R11: table of period measurements, ctrl = en|rld|flagclr|ie
        for (int i = 0; i < 6; i++) begin
            int n;
            wr(2'd0, 16'h0004);
            wr(2'd1, 16'(VEC[i][1]));
            wr(2'd0, 16'(VEC[i][0] << 8) | 16'h000F);
            n = 0;
            while (irq !== 1'b1 && n < 2000) begin
                @(posedge clk);
                #1;
                n++;
            end
            check("R1 first flag delay", n, VEC[i][2]);
            rd(2'd2, rv);
            check("R2 reload to modulus", rv, VEC[i][1]);
        end

        // R9 immediate load
        wr(2'd0, 16'h0004);
        wr(2'd0, 16'h0014);
        wr(2'd1, 16'd1000);
        wr(2'd0, 16'h0017);
        wr(2'd1, 16'd5);
        rd(2'd2, rv); check("R9 immediate load", rv, 16'd5);

        // R9 deferred modulus
        wr(2'd0, 16'h0004);
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd1000);
        wr(2'd0, 16'h0007);
        wr(2'd1, 16'd7);
        rd(2'd2, rv); check("R9 deferred modulus", rv, 16'd999);

        // R7 stopped timer holds count
        wr(2'd0, 16'h0004);
        rd(2'd2, rv);
        check("R7 last tick on disable edge", rv, 16'd998);
        repeat (5) @(posedge clk);
        #1;
        rd(2'd2, rv2); check("R7 frozen count", rv2, rv);
        rd(2'd0, rv2); check("R7 no flag while stopped", rv2[2], 1'b0);

        // R3 free-running wrap
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0005);
        repeat (3) @(posedge clk);
        #1;
        rd(2'd2, rv); check("R3 wrap to ones", rv, 16'hFFFF);
        rd(2'd0, rv); check("R3 flag on wrap", rv[2], 1'b1);
        @(posedge clk);
        #1;
        rd(2'd2, rv); check("R3 continue down", rv, 16'hFFFE);

        // R8 fields locked while running
        wr(2'd0, 16'h0307);
        rd(2'd0, rv); check("R8 prescale and mode unchanged", rv, 16'h0001);

        // R5 clear meets terminal tick; R4 and R6 follow
        wr(2'd0, 16'h0004);
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0007);
        repeat (3) @(posedge clk);
        wr(2'd0, 16'h0007);
        rd(2'd0, rv); check("R5 flag survives clear on tick", rv[2], 1'b1);
        wr(2'd0, 16'h0003);
        rd(2'd0, rv); check("R4 writing zero keeps flag", rv[2], 1'b1);
        check("R6 no irq without enable", irq, 1'b0);
        wr(2'd0, 16'h000B);
        check("R6 irq with enable and flag", irq, 1'b1);
        wr(2'd0, 16'h000F);
        rd(2'd0, rv); check("R4 write one clears flag", rv[2], 1'b0);
        check("R6 irq drops with flag", irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule